// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block walks a linked chain of transfer descriptors kept in memory and drives a simple copy engine with each of them. A one-cycle start pulse arrives together with a table base address. The walker then reads descriptors one 32-bit word at a time through a request/response port: it holds an address and a request until a response returns with data and an error bit.

Each descriptor is three words. The first carries a two-bit control code and a 30-bit source address. The second carries an interrupt-enable bit and a 30-bit destination address. The third carries the byte count. The control code decides what happens next. The walker can run the entry and move on to the next one, skip the entry, jump to another place in the table, or run the entry and stop. For each entry it runs, it pulses a go strobe with source, destination and length to the copy engine, then waits for the engine's done pulse.

Status outputs give busy, a latched error flag, a one-cycle interrupt request, and the address of the descriptor being worked on. An abort input lets the walk drain to idle without starting any new work.

Top module: `sg_walker`

## Requirements
- R1: After reset, busy_o, err_o and irq_o are 0, and neither fetch_req_o nor xfer_go_o is asserted.
- R2: A start_i pulse while idle sets busy_o on the next cycle and loads cur_addr_o with base_i with its two low bits cleared. The walker then requests the descriptor's words at offsets +0, +4 and +8, in that order. fetch_req_o and fetch_addr_o stay unchanged until fetch_rvalid_i arrives.
- R3: Code 2'b00 in word-0 bits [31:30] (run): xfer_go_o pulses for one cycle with xfer_src_o = word0[29:0], xfer_dst_o = word1[29:0] and xfer_len_o = word2. After xfer_done_i the walk continues at the descriptor address plus 12.
- R4: Code 2'b01 (skip): only word 0 is fetched, no go is issued, and the next fetch is at the descriptor address plus 12.
- R5: Code 2'b10 (jump): only word 0 is fetched, no go is issued, and the next descriptor is fetched from word0[29:0] with its two low bits cleared.
- R6: Code 2'b11 (last): the transfer is issued, and when xfer_done_i arrives without error busy_o falls on the next cycle.
- R7: irq_o pulses for exactly one cycle, in the cycle after an error-free xfer_done_i, when word1 bit 31 of that descriptor is set or the descriptor is the last one. It does not pulse otherwise.
- R8: A response with fetch_rerr_i set ends the walk. err_o is set, busy_o falls, and no go is issued. err_o then holds until the next accepted start, which clears it.
- R9: An xfer_done_i with xfer_err_i set ends the walk with err_o set and no irq_o pulse.
- R10: abort_i asserted while busy blocks any new fetch or go. The walker returns to idle once the response or engine completion it is already waiting for arrives.
- R11: start_i while busy has no effect on the walk in progress.
- R12: While busy, cur_addr_o shows the address of the descriptor being processed, including while its transfer is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk at base_i |
| base_i | input | 30 | Table base byte address |
| abort_i | input | 1 | Stop the walk after the current handshake |
| fetch_req_o | output | 1 | Descriptor word read request |
| fetch_addr_o | output | 30 | Byte address of the requested word |
| fetch_rvalid_i | input | 1 | Read response valid |
| fetch_rdata_i | input | 32 | Read response data |
| fetch_rerr_i | input | 1 | Read response error |
| xfer_go_o | output | 1 | One-cycle transfer issue strobe |
| xfer_src_o | output | 30 | Transfer source byte address |
| xfer_dst_o | output | 30 | Transfer destination byte address |
| xfer_len_o | output | 32 | Transfer length in bytes |
| xfer_done_i | input | 1 | Engine completion pulse |
| xfer_err_i | input | 1 | Engine error, valid with xfer_done_i |
| busy_o | output | 1 | Walk in progress |
| err_o | output | 1 | Latched walk error |
| irq_o | output | 1 | One-cycle per-entry interrupt request |
| cur_addr_o | output | 30 | Address of the current descriptor |

## Verification
A response that arrives at one clock edge is taken at that edge. The next word's request, or the go strobe after the third word, is visible one cycle later. busy_o rises one cycle after start_i, and irq_o, err_o and the fall of busy_o all appear one cycle after the done or the response that causes them. The bench drives every input and samples every output on the falling edge, so each sample sees the state left by the previous rising edge. The irq_o timing is checked against the done value that the bench drove for that same edge. Whole-walk results, such as issue counts, the fields and descriptor address seen at each go, fetch order and final flags, are compared after busy_o has fallen.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int ADDR_W     = 30;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 32;
    localparam int DESC_WORDS = 3;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef enum logic [1:0] {
        FLG_RUN  = 2'b00,
        FLG_SKIP = 2'b01,
        FLG_JUMP = 2'b10,
        FLG_LAST = 2'b11
    } flag_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    typedef struct packed {
        flag_e             flag;
        logic              irq_en;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
    } desc_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen
    import sgw_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [IDX_W-1:0]  widx,
    output logic [ADDR_W-1:0] word_addr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    assign word_addr = cur_addr + (ADDR_W'(widx) << SHIFT);
    assign next_addr = cur_addr + ADDR_W'(DESC_BYTES);
endmodule

// File: rtl/sgw_capture.sv
module sgw_capture
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    output desc_t             desc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else if (wr_en) begin
            case (widx)
                IDX_W'(0): begin
                    desc.flag <= flag_e'(wdata[WORD_W-1 -: 2]);
                    desc.src  <= wdata[ADDR_W-1:0];
                end
                IDX_W'(1): begin
                    desc.irq_en <= wdata[WORD_W-1];
                    desc.dst    <= wdata[ADDR_W-1:0];
                end
                default: desc.len <= wdata[LEN_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              abort_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_rvalid_i,
    input  logic [WORD_W-1:0] fetch_rdata_i,
    input  logic              fetch_rerr_i,
    output logic              xfer_go_o,
    output logic [ADDR_W-1:0] xfer_src_o,
    output logic [ADDR_W-1:0] xfer_dst_o,
    output logic [LEN_W-1:0]  xfer_len_o,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] cur_addr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    state_e            state;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  widx;
    logic              abort_q;
    logic              err_q;
    logic              irq_q;
    logic              stop;
    logic              take_word;
    flag_e             rx_flag;
    desc_t             desc;
    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] next_addr;

    sgw_addr_gen u_addr (
        .cur_addr (cur_addr),
        .widx     (widx),
        .word_addr(word_addr),
        .next_addr(next_addr)
    );

    assign take_word = (state == ST_FETCH) && fetch_rvalid_i && !fetch_rerr_i;

    sgw_capture u_cap (
        .clk  (clk),
        .rst  (rst),
        .wr_en(take_word),
        .widx (widx),
        .wdata(fetch_rdata_i),
        .desc (desc)
    );

    assign stop    = abort_q || abort_i;
    assign rx_flag = flag_e'(fetch_rdata_i[WORD_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            widx     <= '0;
            abort_q  <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (state != ST_IDLE && abort_i)
                abort_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_FETCH;
                        cur_addr <= word_align(base_i);
                        widx     <= '0;
                        abort_q  <= 1'b0;
                        err_q    <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_rvalid_i) begin
                        if (fetch_rerr_i) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else if (stop) begin
                            state <= ST_IDLE;
                        end else if (widx == '0 && rx_flag == FLG_SKIP) begin
                            cur_addr <= next_addr;
                        end else if (widx == '0 && rx_flag == FLG_JUMP) begin
                            cur_addr <= word_align(fetch_rdata_i[ADDR_W-1:0]);
                        end else if (widx == LAST_IDX) begin
                            widx  <= '0;
                            state <= ST_ISSUE;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    state <= stop ? ST_IDLE : ST_WAIT;
                end
                default: begin
                    if (xfer_done_i) begin
                        if (xfer_err_i) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            irq_q <= desc.irq_en || (desc.flag == FLG_LAST);
                            if (desc.flag == FLG_LAST || stop) begin
                                state <= ST_IDLE;
                            end else begin
                                cur_addr <= next_addr;
                                state    <= ST_FETCH;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign fetch_req_o  = (state == ST_FETCH);
    assign fetch_addr_o = word_addr;
    assign xfer_go_o    = (state == ST_ISSUE) && !stop;
    assign xfer_src_o   = desc.src;
    assign xfer_dst_o   = desc.dst;
    assign xfer_len_o   = desc.len;
    assign busy_o       = (state != ST_IDLE);
    assign err_o        = err_q;
    assign irq_o        = irq_q;
    assign cur_addr_o   = cur_addr;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!fetch_req_o && !xfer_go_o));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !fetch_rvalid_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

    // R3
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_go_o |=> (busy_o && !xfer_go_o && !fetch_req_o));

    // R7
    irq_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(xfer_done_i) && !$past(xfer_err_i)));

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past((fetch_rvalid_i && fetch_rerr_i) || (xfer_done_i && xfer_err_i)));

    // R10
    abort_no_go_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && abort_i) |=> !xfer_go_o);
endmodule

// File: tb/tb_sg_walker.sv
`timescale 1ns/1ps
module tb_sg_walker;
    import sgw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic              abort_i = 1'b0;
    logic              fetch_req_o;
    logic [ADDR_W-1:0] fetch_addr_o;
    logic              fetch_rvalid_i = 1'b0;
    logic [WORD_W-1:0] fetch_rdata_i = '0;
    logic              fetch_rerr_i = 1'b0;
    logic              xfer_go_o;
    logic [ADDR_W-1:0] xfer_src_o;
    logic [ADDR_W-1:0] xfer_dst_o;
    logic [LEN_W-1:0]  xfer_len_o;
    logic              xfer_done_i = 1'b0;
    logic              xfer_err_i = 1'b0;
    logic              busy_o;
    logic              err_o;
    logic              irq_o;
    logic [ADDR_W-1:0] cur_addr_o;

    always #2 clk = ~clk;

    sg_walker dut (.*);

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:63];
    logic [ADDR_W-1:0] err_addr = '1;
    logic eng_err = 1'b0;

    int n_fetch, n_go, n_irq, irq_bad;
    logic [ADDR_W-1:0] f_log [0:15];
    logic [ADDR_W-1:0] g_src [0:7];
    logic [ADDR_W-1:0] g_dst [0:7];
    logic [LEN_W-1:0]  g_len [0:7];
    logic [ADDR_W-1:0] g_cur [0:7];
    int eng_cnt = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory responder
    initial forever begin
        @(negedge clk);
        if (fetch_req_o && !fetch_rvalid_i) begin
            fetch_rvalid_i = 1'b1;
            fetch_rdata_i  = mem[fetch_addr_o[7:2]];
            fetch_rerr_i   = (fetch_addr_o == err_addr);
            if (n_fetch < 16) f_log[n_fetch] = fetch_addr_o;
            n_fetch++;
        end else begin
            fetch_rvalid_i = 1'b0;
            fetch_rerr_i   = 1'b0;
        end
    end

    // copy engine model and irq monitor
    initial forever begin
        @(negedge clk);
        if (irq_o) begin
            n_irq++;
            if (!xfer_done_i || xfer_err_i) irq_bad++;
        end
        xfer_done_i = 1'b0;
        xfer_err_i  = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                xfer_done_i = 1'b1;
                xfer_err_i  = eng_err;
            end
        end
        if (xfer_go_o) begin
            if (n_go < 8) begin
                g_src[n_go] = xfer_src_o;
                g_dst[n_go] = xfer_dst_o;
                g_len[n_go] = xfer_len_o;
                g_cur[n_go] = cur_addr_o;
            end
            n_go++;
            eng_cnt = 3;
        end
    end

    task automatic clear_all();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        n_fetch = 0; n_go = 0; n_irq = 0; irq_bad = 0;
        err_addr = '1; eng_err = 1'b0;
    endtask

    task automatic put_desc(input int a, input logic [1:0] fl, input logic ie,
                            input logic [29:0] s, input logic [29:0] d, input logic [31:0] l);
        mem[(a >> 2) & 63]       = {fl, s};
        mem[((a >> 2) + 1) & 63] = {ie, 1'b0, d};
        mem[((a >> 2) + 2) & 63] = l;
    endtask

    task automatic pulse_start(input logic [ADDR_W-1:0] b);
        base_i  = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        checks++;
        if (t >= 2000) begin
            errors++;
            $display("FAIL %s: watchdog, busy stuck actual 1 expected 0", req);
        end
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  flag;
        logic        ie;
        logic [29:0] src;
        logic [3:0]  exp_go;
        logic [3:0]  exp_irq;
        logic [3:0]  exp_fetch;
        logic [29:0] exp_src;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{2'b00, 1'b0, 30'h100, 4'd2, 4'd1, 4'd6, 30'h100},
        '{2'b00, 1'b1, 30'h104, 4'd2, 4'd2, 4'd6, 30'h104},
        '{2'b01, 1'b0, 30'h108, 4'd1, 4'd1, 4'd4, 30'h111},
        '{2'b10, 1'b0, 30'h080, 4'd1, 4'd1, 4'd4, 30'h333},
        '{2'b11, 1'b0, 30'h10c, 4'd1, 4'd1, 4'd3, 30'h10c},
        '{2'b11, 1'b1, 30'h110, 4'd1, 4'd1, 4'd3, 30'h110}
    };

    task automatic std_chain(input vec_t v);
        clear_all();
        put_desc(0, v.flag, v.ie, v.src, v.src + 30'h1000, 32'h20);
        put_desc(12, 2'b11, 1'b0, 30'h111, 30'h222, 32'd16);
        put_desc(128, 2'b11, 1'b0, 30'h333, 30'h444, 32'd8);
    endtask

    initial begin
        int t;
        clear_all();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 err", err_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 req", fetch_req_o, 0);
        check("R1 go", xfer_go_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // table-driven walks: R3 R4 R5 R6 R7
        for (int k = 0; k < 6; k++) begin
            std_chain(VECS[k]);
            pulse_start(30'h0);
            wait_idle("R6");
            check("R3 go count", n_go, VECS[k].exp_go);
            check("R7 irq count", n_irq, VECS[k].exp_irq);
            check("R4 R5 fetch count", n_fetch, VECS[k].exp_fetch);
            check("R3 first src", g_src[0], VECS[k].exp_src);
            check("R6 busy low", busy_o, 0);
            check("R7 irq timing", irq_bad, 0);
            if (VECS[k].flag == 2'b00) begin
                check("R3 dst", g_dst[0], VECS[k].src + 30'h1000);
                check("R3 len", g_len[0], 32'h20);
                check("R3 next at +12", g_src[1], 30'h111);
                check("R12 cur at second go", g_cur[1], 30'd12);
            end
            if (VECS[k].flag == 2'b01) check("R4 next fetch", f_log[1], 30'd12);
            if (VECS[k].flag == 2'b10) check("R5 jump fetch", f_log[1], 30'h80);
        end

        // R2 alignment and fetch order
        clear_all();
        put_desc(64, 2'b11, 1'b0, 30'h55, 30'h66, 32'd4);
        pulse_start(30'h43);
        check("R2 busy next cycle", busy_o, 1);
        check("R2 aligned cur", cur_addr_o, 30'h40);
        wait_idle("R2");
        check("R2 fetch 0", f_log[0], 30'h40);
        check("R2 fetch 1", f_log[1], 30'h44);
        check("R2 fetch 2", f_log[2], 30'h48);

        // R8 fetch error, held, cleared by start
        std_chain(VECS[0]);
        err_addr = 30'h4;
        pulse_start(30'h0);
        wait_idle("R8");
        check("R8 no go", n_go, 0);
        check("R8 err set", err_o, 1);
        repeat (5) @(negedge clk);
        check("R8 err held", err_o, 1);
        err_addr = '1;
        pulse_start(30'h0);
        check("R8 err cleared by start", err_o, 0);
        wait_idle("R8");

        // R9 engine error
        std_chain(VECS[1]);
        eng_err = 1'b1;
        pulse_start(30'h0);
        wait_idle("R9");
        check("R9 err set", err_o, 1);
        check("R9 single go", n_go, 1);
        check("R9 no irq", n_irq, 0);
        eng_err = 1'b0;

        // R10 abort during transfer
        std_chain(VECS[0]);
        pulse_start(30'h0);
        t = 0;
        while (n_go == 0 && t < 200) begin @(negedge clk); t++; end
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        wait_idle("R10");
        check("R10 go count", n_go, 1);
        check("R10 fetch count", n_fetch, 3);
        check("R10 busy low", busy_o, 0);

        // R11 start while busy ignored
        std_chain(VECS[0]);
        pulse_start(30'h0);
        repeat (2) @(negedge clk);
        pulse_start(30'h80);
        wait_idle("R11");
        check("R11 go count", n_go, 2);
        check("R11 first src", g_src[0], 30'h100);
        check("R11 second src", g_src[1], 30'h111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule